// File: doc/BRIEF.md
# USB Device Interrupt Status Aggregator

This block gathers the interrupt sources of a USB device controller into one 32-bit status word and drives a single level interrupt line towards a host processor. Hardware events from the endpoints, the bus-state detector and the DMA engine arrive as one-cycle pulses. Each pulse sets a sticky status bit, and the bit holds until software clears it. The processor reads the status word and a separate DMA cause word over a small register port. It clears bits by writing ones to them.

The DMA engine has one summary bit in the status word. Its detailed causes live in the DMA cause word. Software clears a DMA interrupt in two steps: first it writes 1 to the cause bits in the cause word, then it writes 1 to the summary bit. A USB bus reset empties both words, except for the bit that records the bus reset itself.

Top module: `usbd_irq_agg`

## Requirements
- R1: `irq` is high in exactly those cycles in which the status word (read at address 0) is non-zero. It changes on the same clock edge as the status word.
- R2: While `rst_n` is low at a clock edge, both readable words become zero and `irq` becomes 0.
- R3: For endpoint n, an `ep_rx_evt[n]` pulse sets status bit 10+2n and an `ep_tx_evt[n]` pulse sets status bit 11+2n. Endpoint 0 therefore uses bits 11:10 and endpoint 7 uses bits 25:24.
- R4: Bus and control events set fixed status bits:
  - bus reset sets bit 0;
  - resume sets bit 1;
  - suspend sets bit 2;
  - pseudo start-of-frame sets bit 3;
  - start-of-frame sets bit 4;
  - an endpoint 0 setup packet sets bit 8.
- R5: A write to address 0 clears every status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R6: If a set event and a clearing write hit the same bit in the same cycle, the bit is 1 afterwards.
- R7: Status bits 5, 7, 9 and 26 to 31 always read 0, and writes do not change them. Bits of the cause word at or above DMA_SRC_W also read 0.
- R8: The DMA cause word is read at address 1. A `dma_evt[k]` pulse sets its bit k. A write to address 1 clears the cause bits whose write-data bit is 1.
- R9: Status bit 6 is set by any `dma_evt` pulse. A write of 1 to bit 6 clears it only if the cause word read 0 before that write's clock edge. Otherwise the write leaves bit 6 at 1.
- R10: A `bus_reset_evt` pulse overrides every other event and write in its cycle. After that edge the status word reads exactly 1 (only bit 0) and the cause word reads 0.
- R11: An event or write applied before a clock edge is visible at `reg_rdata` directly after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ep_rx_evt | input | NUM_EP | Per-endpoint receive event pulses |
| ep_tx_evt | input | NUM_EP | Per-endpoint transmit event pulses |
| setup_evt | input | 1 | Setup packet received on endpoint 0 |
| bus_reset_evt | input | 1 | USB bus reset detected |
| resume_evt | input | 1 | Resume signalling detected |
| suspend_evt | input | 1 | Suspend state entered |
| psof_evt | input | 1 | Pseudo start-of-frame tick |
| sof_evt | input | 1 | Start-of-frame received |
| dma_evt | input | DMA_SRC_W | DMA cause pulses |
| reg_addr | input | 1 | 0 selects the status word, 1 selects the DMA cause word |
| reg_wr | input | 1 | Write strobe (write-1-to-clear) |
| reg_wdata | input | 32 | Write data; ones mark the bits to clear |
| reg_rdata | output | 32 | Selected word, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
Two functions can fall in the same cycle: a hardware set and a software clear of one bit, and a bus reset and a pending write. The DMA summary clear can also land in the cycle where a new cause arrives. The bench provokes these collisions directly: it pulses an endpoint event together with a write that clears that bit, and it fires a bus reset together with a clearing write and a DMA event. A randomised phase then mixes events and writes densely, so such collisions recur many times. Every cycle is judged against a behavioural reference model of both words and of `irq`, in which set beats clear and bus reset beats everything.

// File: rtl/usbd_irq_pkg.sv
// Package: bit positions of the status word and the mask of bits that
// hold state. Assumes at most MAX_EP endpoints packed from EP_BASE up.
package usbd_irq_pkg;

    localparam int STAT_W      = 32;
    localparam int BIT_BUSRST  = 0;
    localparam int BIT_RESUME  = 1;
    localparam int BIT_SUSPEND = 2;
    localparam int BIT_PSOF    = 3;
    localparam int BIT_SOF     = 4;
    localparam int BIT_DMA     = 6;
    localparam int BIT_SETUP   = 8;
    localparam int EP_BASE     = 10;
    localparam int MAX_EP      = 8;

    // Status bits held by the generic sticky bank (all except the DMA summary).
    function automatic logic [STAT_W-1:0] bank_mask(input int num_ep);
        logic [STAT_W-1:0] m;
        m = '0;
        m[BIT_BUSRST]  = 1'b1;
        m[BIT_RESUME]  = 1'b1;
        m[BIT_SUSPEND] = 1'b1;
        m[BIT_PSOF]    = 1'b1;
        m[BIT_SOF]     = 1'b1;
        m[BIT_SETUP]   = 1'b1;
        for (int n = 0; n < num_ep; n++) begin
            m[EP_BASE + 2*n]     = 1'b1;
            m[EP_BASE + 2*n + 1] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_sticky_bank.sv
// Sticky write-1-to-clear bit bank. Only bits marked in IMPL get a flop;
// the other bits are tied to 0. Per-bit priority: flush, then set, then
// clear, then hold. Also exposes the next-state vector.
module irq_sticky_bank #(
    parameter int           W    = 32,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic [W-1:0] flush_val,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] q,
    output logic [W-1:0] q_next
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_live
            logic cur;
            logic nxt;

            // Next-state selection with set winning over clear.
            always_comb begin
                if (flush)           nxt = flush_val[i];
                else if (set_vec[i]) nxt = 1'b1;
                else if (clr_vec[i]) nxt = 1'b0;
                else                 nxt = cur;
            end

            // State flop with synchronous reset.
            always_ff @(posedge clk) begin
                if (!rst_n) cur <= 1'b0;
                else        cur <= nxt;
            end

            assign q[i]      = cur;
            assign q_next[i] = nxt;

            // R6: a set event always leaves the bit high.
            a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (set_vec[i] && !flush) |=> q[i]);
            // R5: a clearing write without a set drops the bit.
            a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_vec[i] && !set_vec[i] && !flush) |=> !q[i]);
        end else begin : g_tied
            logic unused_bits;
            assign unused_bits = ^{flush_val[i], set_vec[i], clr_vec[i]};
            assign q[i]        = 1'b0;
            assign q_next[i]   = 1'b0;
        end
    end

endmodule

// File: rtl/dma_summary_flag.sv
// DMA summary flag. Set by any DMA cause pulse. A clear request works only
// when the cause word is already empty. A flush forces the flag to 0.
module dma_summary_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic set_evt,
    input  logic clr_req,
    input  logic reason_empty,
    output logic flag,
    output logic flag_next
);

    // Next state: flush, then set, then a gated clear.
    always_comb begin
        if (flush)                        flag_next = 1'b0;
        else if (set_evt)                 flag_next = 1'b1;
        else if (clr_req && reason_empty) flag_next = 1'b0;
        else                              flag_next = flag;
    end

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= flag_next;
    end

    // R9: the flag cannot drop while a cause is still recorded.
    a_r9_hold_while_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!reason_empty && !flush) |=> flag);
    // R9: a clear on an empty cause word, with no new cause, drops the flag.
    a_r9_clear_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && reason_empty && !set_evt && !flush) |=> !flag);

endmodule

// File: rtl/irq_level_reg.sv
// Registered interrupt level. It is the OR of the next status word, so
// the line rises and falls on the same edge as the status flops.
module irq_level_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status_next,
    output logic         irq
);

    // Flop the reduction so that the output is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |status_next;
    end

endmodule

// File: rtl/usbd_irq_agg.sv
// Top of the USB device interrupt aggregator. It maps event pulses onto
// the status word, decodes the two-word write-1-to-clear register port and
// drives the level interrupt. Assumes NUM_EP <= MAX_EP and
// DMA_SRC_W <= 32. Event inputs are synchronous one-cycle pulses.
module usbd_irq_agg
    import usbd_irq_pkg::*;
#(
    parameter int NUM_EP    = 8,
    parameter int DMA_SRC_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_EP-1:0]    ep_rx_evt,
    input  logic [NUM_EP-1:0]    ep_tx_evt,
    input  logic                 setup_evt,
    input  logic                 bus_reset_evt,
    input  logic                 resume_evt,
    input  logic                 suspend_evt,
    input  logic                 psof_evt,
    input  logic                 sof_evt,
    input  logic [DMA_SRC_W-1:0] dma_evt,
    input  logic                 reg_addr,
    input  logic                 reg_wr,
    input  logic [STAT_W-1:0]    reg_wdata,
    output logic [STAT_W-1:0]    reg_rdata,
    output logic                 irq
);

    localparam logic [STAT_W-1:0] BANK_IMPL = bank_mask(NUM_EP);
    localparam logic [STAT_W-1:0] FLUSH_VAL = STAT_W'(1) << BIT_BUSRST;

    logic [STAT_W-1:0]    stat_set;
    logic [STAT_W-1:0]    stat_clr;
    logic [STAT_W-1:0]    bank_q;
    logic [STAT_W-1:0]    bank_next;
    logic [DMA_SRC_W-1:0] cause_clr;
    logic [DMA_SRC_W-1:0] cause_q;
    logic [DMA_SRC_W-1:0] cause_next;
    logic                 dma_flag;
    logic                 dma_flag_next;
    logic [STAT_W-1:0]    status_q;
    logic [STAT_W-1:0]    status_next;

    // Map the event pulses onto their status positions.
    always_comb begin
        stat_set              = '0;
        stat_set[BIT_BUSRST]  = bus_reset_evt;
        stat_set[BIT_RESUME]  = resume_evt;
        stat_set[BIT_SUSPEND] = suspend_evt;
        stat_set[BIT_PSOF]    = psof_evt;
        stat_set[BIT_SOF]     = sof_evt;
        stat_set[BIT_SETUP]   = setup_evt;
        for (int n = 0; n < NUM_EP; n++) begin
            stat_set[EP_BASE + 2*n]     = ep_rx_evt[n];
            stat_set[EP_BASE + 2*n + 1] = ep_tx_evt[n];
        end
    end

    // Decode the clearing writes for both words.
    always_comb begin
        stat_clr  = (reg_wr && !reg_addr) ? reg_wdata : '0;
        cause_clr = (reg_wr &&  reg_addr) ? reg_wdata[DMA_SRC_W-1:0] : '0;
    end

    irq_sticky_bank #(
        .W    (STAT_W),
        .IMPL (BANK_IMPL)
    ) u_stat_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (bus_reset_evt),
        .flush_val (FLUSH_VAL),
        .set_vec   (stat_set),
        .clr_vec   (stat_clr),
        .q         (bank_q),
        .q_next    (bank_next)
    );

    irq_sticky_bank #(
        .W    (DMA_SRC_W),
        .IMPL ({DMA_SRC_W{1'b1}})
    ) u_cause_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (bus_reset_evt),
        .flush_val ('0),
        .set_vec   (dma_evt),
        .clr_vec   (cause_clr),
        .q         (cause_q),
        .q_next    (cause_next)
    );

    dma_summary_flag u_dma_flag (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (bus_reset_evt),
        .set_evt      (|dma_evt),
        .clr_req      (stat_clr[BIT_DMA]),
        .reason_empty (cause_q == '0),
        .flag         (dma_flag),
        .flag_next    (dma_flag_next)
    );

    // Merge the bank and the summary flag into the visible status word.
    always_comb begin
        status_q             = bank_q;
        status_q[BIT_DMA]    = dma_flag;
        status_next          = bank_next;
        status_next[BIT_DMA] = dma_flag_next;
    end

    irq_level_reg #(
        .W (STAT_W)
    ) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .status_next (status_next),
        .irq         (irq)
    );

    // Read multiplexer for the two words.
    always_comb begin
        if (reg_addr) reg_rdata = STAT_W'(cause_q);
        else          reg_rdata = status_q;
    end

    logic unused_cause_next;
    assign unused_cause_next = ^cause_next;

    // R1: the interrupt level follows whether any status bit is set.
    a_r1_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (status_q != '0));
    // R10: a bus reset leaves only its own bit and an empty cause word.
    a_r10_bus_reset_flush: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_evt |=> (status_q == FLUSH_VAL) && (cause_q == '0));

endmodule

// File: tb/usbd_irq_agg_test.sv
module usbd_irq_agg_test;

    localparam int NEP = 8;
    localparam int DW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NEP-1:0] ep_rx_evt = '0, ep_tx_evt = '0;
    logic          setup_evt = 0, bus_reset_evt = 0, resume_evt = 0;
    logic          suspend_evt = 0, psof_evt = 0, sof_evt = 0;
    logic [DW-1:0] dma_evt = '0;
    logic          reg_addr = 0, reg_wr = 0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit model_on = 0;
    logic [31:0]   m_stat = '0;
    logic [DW-1:0] m_cause = '0;
    logic [31:0]   live_mask;

    usbd_irq_agg #(.NUM_EP(NEP), .DMA_SRC_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .ep_rx_evt(ep_rx_evt), .ep_tx_evt(ep_tx_evt),
        .setup_evt(setup_evt), .bus_reset_evt(bus_reset_evt), .resume_evt(resume_evt),
        .suspend_evt(suspend_evt), .psof_evt(psof_evt), .sof_evt(sof_evt),
        .dma_evt(dma_evt), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Reference model, updated from the inputs held across the edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_stat  = '0;
            m_cause = '0;
        end else if (bus_reset_evt) begin
            m_stat  = 32'h1;
            m_cause = '0;
        end else begin
            logic [31:0]   ns;
            logic [DW-1:0] nc;
            ns = m_stat;
            nc = m_cause;
            if (reg_wr && !reg_addr) ns = ns & ~(reg_wdata & live_mask);
            if (reg_wr && reg_addr)  nc = nc & ~reg_wdata[DW-1:0];
            for (int n = 0; n < NEP; n++) begin
                if (ep_rx_evt[n]) ns[10 + 2*n] = 1'b1;
                if (ep_tx_evt[n]) ns[11 + 2*n] = 1'b1;
            end
            if (resume_evt)  ns[1] = 1'b1;
            if (suspend_evt) ns[2] = 1'b1;
            if (psof_evt)    ns[3] = 1'b1;
            if (sof_evt)     ns[4] = 1'b1;
            if (setup_evt)   ns[8] = 1'b1;
            nc = nc | dma_evt;
            if (dma_evt != '0) ns[6] = 1'b1;
            else if (reg_wr && !reg_addr && reg_wdata[6] && m_cause == '0) ns[6] = 1'b0;
            else ns[6] = m_stat[6];
            m_stat  = ns;
            m_cause = nc;
        end
    end

    // Per-cycle comparison, well clear of both clock edges.
    always @(posedge clk) begin
        #2;
        if (model_on) begin
            chk("R1 irq level", {31'b0, irq}, {31'b0, m_stat != '0});
            chk("R11 read after edge", reg_rdata, reg_addr ? {24'b0, m_cause} : m_stat);
        end
    end

    // Watchdog.
    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic clear_inputs();
        ep_rx_evt = '0; ep_tx_evt = '0; setup_evt = 0; bus_reset_evt = 0;
        resume_evt = 0; suspend_evt = 0; psof_evt = 0; sof_evt = 0;
        dma_evt = '0; reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic tick();
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic rd(input logic a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        reg_addr = a; reg_wr = 1; reg_wdata = d;
    endtask

    initial begin
        logic [31:0] v;
        live_mask = 32'h0;
        live_mask[4:0] = 5'h1f;
        live_mask[8]   = 1'b1;
        for (int n = 0; n < 2*NEP; n++) live_mask[10 + n] = 1'b1;

        repeat (3) @(negedge clk);
        rst_n = 1;
        model_on = 1;
        rd(0, v); chk("R2 reset status", v, 32'h0);
        rd(1, v); chk("R2 reset cause", v, 32'h0);
        chk("R2 reset irq", {31'b0, irq}, 32'h0);

        // R3: endpoint pairs.
        ep_tx_evt[3] = 1; tick();
        rd(0, v); chk("R3 ep3 tx bit17", v, 32'h0002_0000);
        ep_rx_evt[0] = 1; ep_tx_evt[7] = 1; tick();
        rd(0, v); chk("R3 ep0 rx/ep7 tx", v, 32'h0202_0400);
        chk("R1 irq set", {31'b0, irq}, 32'h1);

        // R5: zeros keep bits, ones clear.
        wr(0, 32'h0); tick();
        rd(0, v); chk("R5 write zero keeps", v, 32'h0202_0400);
        wr(0, 32'h0002_0000); tick();
        rd(0, v); chk("R5 w1c one bit", v, 32'h0200_0400);

        // R4: control and bus events.
        setup_evt = 1; resume_evt = 1; suspend_evt = 1; psof_evt = 1; sof_evt = 1; tick();
        rd(0, v); chk("R4 bus/setup bits", v, 32'h0200_051e);

        // R6: set and clear on the same bit in the same cycle.
        ep_rx_evt[5] = 1; wr(0, 32'h0010_0000); tick();
        rd(0, v); chk("R6 set beats clear", v & 32'h0010_0000, 32'h0010_0000);

        // R7: clear all; reserved positions never read back.
        wr(0, 32'hffff_ffff); tick();
        rd(0, v); chk("R7 all cleared, reserved zero", v, 32'h0);
        chk("R1 irq drops", {31'b0, irq}, 32'h0);
        wr(1, 32'hffff_ffff); tick();
        rd(1, v); chk("R7 cause upper bits zero", v, 32'h0);

        // R8/R9: two-step DMA clear.
        dma_evt = 8'h04; tick();
        rd(1, v); chk("R8 cause bit2", v, 32'h4);
        rd(0, v); chk("R9 summary set", v, 32'h40);
        wr(0, 32'h40); tick();
        rd(0, v); chk("R9 clear blocked by cause", v, 32'h40);
        wr(1, 32'h4); tick();
        rd(1, v); chk("R8 cause cleared", v, 32'h0);
        rd(0, v); chk("R9 summary still set", v, 32'h40);
        wr(0, 32'h40); tick();
        rd(0, v); chk("R9 summary cleared", v, 32'h0);

        // R10: bus reset against a write and a DMA cause.
        ep_tx_evt[2] = 1; sof_evt = 1; tick();
        dma_evt = 8'h81; tick();
        bus_reset_evt = 1; dma_evt = 8'h02; ep_rx_evt[1] = 1; wr(0, 32'h1); tick();
        rd(0, v); chk("R10 status after bus reset", v, 32'h1);
        rd(1, v); chk("R10 cause after bus reset", v, 32'h0);

        // Dense random mix.
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            clear_inputs();
            ep_rx_evt = NEP'($urandom & $urandom & $urandom);
            ep_tx_evt = NEP'($urandom & $urandom & $urandom);
            setup_evt = ($urandom % 8) == 0;
            resume_evt = ($urandom % 10) == 0;
            suspend_evt = ($urandom % 10) == 0;
            psof_evt = ($urandom % 10) == 0;
            sof_evt = ($urandom % 10) == 0;
            bus_reset_evt = ($urandom % 60) == 0;
            if (($urandom % 4) == 0) dma_evt = DW'(1 << ($urandom % DW));
            reg_addr = $urandom % 2;
            if (($urandom % 2) == 0) begin
                reg_wr = 1;
                reg_wdata = $urandom | $urandom;
            end
        end
        @(negedge clk);
        clear_inputs();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule